// File: doc/BRIEF.md
# Processor/Host Mailbox Register Bridge

This block sits between a host I/O port and the small processor inside a disk controller. It is a byte-wide mailbox. The processor picks one of eight operations with a 3-bit address. It moves bytes over a shared bidirectional bus, using separate read and write strobes, and both strobes only count while an enable input is high. Through these operations the processor reads switches and flags, loads a mode byte, takes host bytes, hands bytes and status back, and sets or clears the request flags that make up the handshake.

The host side has a 2-bit address, a chip select and separate read and write strobes. Its read data is a plain output. A DMA request output and an interrupt output complete the host side. All state changes on the rising clock edge. Reset is synchronous and active high. When one flag has a set condition and a clear condition in the same cycle, the set takes effect.

Top module: `mbox_bridge`

## Requirements
- R1: Synchronous reset clears every flag, the mode byte and the data and status registers. After reset, h_drq and h_int are 0.
- R2: Processor strobes have no effect while c_en is 0. The bus stays undriven and no register or flag changes.
- R3: Processor read at address 0 returns {host-request flag, sw_n[6:0]}, with the flag in bit 7 and the switches passed through raw.
- R4: A host write to address 0 stores h_din in the host-data register, sets host-data-valid and clears the host-request flag. A processor read at address 2 returns that byte and clears host-data-valid.
- R5: A processor write at address 1 loads the mode byte, which reads back at processor address 1. A processor write at address 2 loads status 1, which the host reads at address 2.
- R6: A processor write at address 3 sets the host-request flag. A processor write at address 4 sets the controller-request flag, and a host read of address 0 clears it.
- R7: A processor write at address 6 loads the controller-data byte, which the host reads at address 0, and sets data-ready. A host read of address 0 clears data-ready. h_drq equals data-ready AND mode bit 0.
- R8: A processor write at address 7 loads status 0 and raises h_int. A host read of address 1 returns status 0 and lowers h_int.
- R9: A host write to address 2 sets the DMA-end flag. A processor write at address 5 clears it.
- R10: c_data is driven only while c_en and c_rd are both 1. Addresses 3 to 7 then return 0. At all other times c_data is high impedance.
- R11: When one flag sees its set and its clear in the same cycle, it ends up set.
- R12: The host reads at address 3 the flag byte {3'b0, data-ready, DMA-end, controller-request, host-request, host-data-valid}, bit 0 last. Host strobes with h_cs at 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| c_addr | input | 3 | Processor operation select |
| c_en | input | 1 | Processor strobe enable |
| c_rd | input | 1 | Processor read strobe |
| c_wr | input | 1 | Processor write strobe |
| c_data | inout | 8 | Processor bidirectional data bus |
| sw_n | input | 7 | Active-low switch inputs |
| h_addr | input | 2 | Host register select |
| h_cs | input | 1 | Host chip select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data |
| h_drq | output | 1 | DMA request to host |
| h_int | output | 1 | Interrupt to host |

## Verification
Read data on both sides is combinational. c_data and h_dout reflect the current address and register contents in the same cycle as the strobe. Every flag, register and the h_drq and h_int outputs change one clock edge after the strobe that caused them. The bench drives inputs on the falling edge and compares all outputs 1 ns later. It advances its behavioural model on the rising edge, so each effect is checked in the cycle after its cause. Each same-cycle read is checked in the cycle it is issued.

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    c_addr,
  input  logic          c_en,
  input  logic          c_rd,
  input  logic          c_wr,
  inout  wire  [DW-1:0] c_data,
  input  logic [DW-2:0] sw_n,
  input  logic [1:0]    h_addr,
  input  logic          h_cs,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [DW-1:0] h_din,
  output logic [DW-1:0] h_dout,
  output logic          h_drq,
  output logic          h_int
);
  localparam logic [2:0] OP_SW   = 3'd0, OP_MODE = 3'd1, OP_HDAT = 3'd2, OP_HREQ = 3'd3,
                         OP_CREQ = 3'd4, OP_DEND = 3'd5, OP_CDAT = 3'd6, OP_ST0  = 3'd7;

  logic [DW-1:0] mode, stat0, stat1, cdata, hdata;
  logic hvalid, hreq, creq, dend, crdy, irq;

  wire cw = c_en & c_wr;
  wire cr = c_en & c_rd;
  wire hw = h_cs & h_wr;
  wire hr = h_cs & h_rd;

  wire c_op_w_mode = cw && c_addr == OP_MODE;
  wire c_op_w_st1  = cw && c_addr == OP_HDAT;
  wire c_op_r_hdat = cr && c_addr == OP_HDAT;
  wire c_op_hreq   = cw && c_addr == OP_HREQ;
  wire c_op_creq   = cw && c_addr == OP_CREQ;
  wire c_op_dend   = cw && c_addr == OP_DEND;
  wire c_op_cdat   = cw && c_addr == OP_CDAT;
  wire c_op_st0    = cw && c_addr == OP_ST0;
  wire h_wdat      = hw && h_addr == 2'd0;
  wire h_wend      = hw && h_addr == 2'd2;
  wire h_rdat      = hr && h_addr == 2'd0;
  wire h_rsta      = hr && h_addr == 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0; stat0 <= '0; stat1 <= '0; cdata <= '0; hdata <= '0;
      hvalid <= 1'b0; hreq <= 1'b0; creq <= 1'b0;
      dend <= 1'b0; crdy <= 1'b0; irq <= 1'b0;
    end else begin
      if (c_op_w_mode) mode  <= c_data;
      if (c_op_w_st1)  stat1 <= c_data;
      if (c_op_cdat)   cdata <= c_data;
      if (c_op_st0)    stat0 <= c_data;
      if (h_wdat)      hdata <= h_din;
      hvalid <= h_wdat    | (hvalid & ~c_op_r_hdat);
      hreq   <= c_op_hreq | (hreq   & ~h_wdat);
      creq   <= c_op_creq | (creq   & ~h_rdat);
      dend   <= h_wend    | (dend   & ~c_op_dend);
      crdy   <= c_op_cdat | (crdy   & ~h_rdat);
      irq    <= c_op_st0  | (irq    & ~h_rsta);
    end
  end

  logic [DW-1:0] c_rdata;
  always_comb begin
    case (c_addr)
      OP_SW:   c_rdata = {hreq, sw_n};
      OP_MODE: c_rdata = mode;
      OP_HDAT: c_rdata = hdata;
      default: c_rdata = '0;
    endcase
  end
  assign c_data = cr ? c_rdata : {DW{1'bz}};

  always_comb begin
    case (h_addr)
      2'd0:    h_dout = cdata;
      2'd1:    h_dout = stat0;
      2'd2:    h_dout = stat1;
      default: h_dout = {{(DW-5){1'b0}}, crdy, dend, creq, hreq, hvalid};
    endcase
  end

  assign h_drq = crdy & mode[0];
  assign h_int = irq;
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] c_addr,
  input logic       c_en,
  input logic       c_wr,
  input logic [1:0] h_addr,
  input logic       h_cs,
  input logic       h_rd,
  input logic       h_wr,
  input logic       h_drq,
  input logic       h_int,
  input logic [7:0] mode,
  input logic       hvalid
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) rst |=> (!h_int && !h_drq));

  p_gated_mode_r2: assert property (@(posedge clk) disable iff (rst)
    !c_en |=> $stable(mode));

  p_hvalid_set_r4: assert property (@(posedge clk) disable iff (rst)
    (h_cs && h_wr && h_addr == 2'd0) |=> hvalid);

  p_drq_mode_r7: assert property (@(posedge clk) disable iff (rst)
    h_drq |-> mode[0]);

  p_int_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (c_en && c_wr && c_addr == 3'd7) |=> h_int);

  p_int_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (h_cs && h_rd && h_addr == 2'd1 && !(c_en && c_wr && c_addr == 3'd7)) |=> !h_int);
endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
  .clk(clk), .rst(rst), .c_addr(c_addr), .c_en(c_en), .c_wr(c_wr),
  .h_addr(h_addr), .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr),
  .h_drq(h_drq), .h_int(h_int), .mode(mode), .hvalid(hvalid)
);

// File: tb/tb_mbox_bridge.sv
`timescale 1ns/100ps
module tb_mbox_bridge;
  logic clk = 0, rst = 1;
  logic [2:0] c_addr = 0;
  logic c_en = 0, c_rd = 0, c_wr = 0;
  logic [7:0] c_drv = 0;
  logic [6:0] sw_n = 7'h55;
  logic [1:0] h_addr = 0;
  logic h_cs = 0, h_rd = 0, h_wr = 0;
  logic [7:0] h_din = 0;
  wire  [7:0] c_data;
  logic [7:0] h_dout;
  logic h_drq, h_int;

  assign c_data = (c_en && c_wr && !c_rd) ? c_drv : 8'hzz;

  always #2.5 clk = ~clk;

  mbox_bridge dut (.clk(clk), .rst(rst), .c_addr(c_addr), .c_en(c_en), .c_rd(c_rd),
    .c_wr(c_wr), .c_data(c_data), .sw_n(sw_n), .h_addr(h_addr), .h_cs(h_cs),
    .h_rd(h_rd), .h_wr(h_wr), .h_din(h_din), .h_dout(h_dout), .h_drq(h_drq), .h_int(h_int));

  int checks = 0, fails = 0;
  string tag = "R1";

  // reference model state
  logic [7:0] m_mode, m_s0, m_s1, m_cd, m_hd;
  bit m_hv, m_hq, m_cq, m_de, m_cr, m_irq;

  task automatic model_reset();
    m_mode = 0; m_s0 = 0; m_s1 = 0; m_cd = 0; m_hd = 0;
    m_hv = 0; m_hq = 0; m_cq = 0; m_de = 0; m_cr = 0; m_irq = 0;
  endtask

  task automatic model_step();
    bit cw, cr, hw, hr;
    cw = c_en && c_wr; cr = c_en && c_rd; hw = h_cs && h_wr; hr = h_cs && h_rd;
    if (rst) begin model_reset(); return; end
    // clears first, then sets, so a set wins (R11)
    if (cr && c_addr == 2) m_hv = 0;
    if (hw && h_addr == 0) m_hq = 0;
    if (hr && h_addr == 0) begin m_cq = 0; m_cr = 0; end
    if (cw && c_addr == 5) m_de = 0;
    if (hr && h_addr == 1) m_irq = 0;
    if (hw && h_addr == 0) begin m_hd = h_din; m_hv = 1; end
    if (hw && h_addr == 2) m_de = 1;
    if (cw) begin
      case (c_addr)
        1: m_mode = c_drv;
        2: m_s1 = c_drv;
        3: m_hq = 1;
        4: m_cq = 1;
        6: begin m_cd = c_drv; m_cr = 1; end
        7: begin m_s0 = c_drv; m_irq = 1; end
        default: ;
      endcase
    end
  endtask

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] eh, ec;
    case (h_addr)
      0: eh = m_cd;
      1: eh = m_s0;
      2: eh = m_s1;
      default: eh = {3'b0, m_cr, m_de, m_cq, m_hq, m_hv};
    endcase
    if (c_en && c_rd)
      case (c_addr)
        0: ec = {m_hq, sw_n};
        1: ec = m_mode;
        2: ec = m_hd;
        default: ec = 8'h00;
      endcase
    else if (c_en && c_wr) ec = c_drv;
    else ec = 8'hzz;
    cmp(h_dout, eh, "h_dout");
    cmp({7'b0, h_drq}, {7'b0, m_cr & m_mode[0]}, "h_drq");
    cmp({7'b0, h_int}, {7'b0, m_irq}, "h_int");
    cmp(c_data, ec, "c_data");
  endtask

  // inputs set after falling edge; compare 1 ns later; model advances at rising edge
  task automatic cyc(input bit ce, input bit crd, input bit cwr, input logic [2:0] ca,
                     input logic [7:0] cd, input bit hcs, input bit hrd, input bit hwr,
                     input logic [1:0] ha, input logic [7:0] hd);
    c_en = ce; c_rd = crd; c_wr = cwr; c_addr = ca; c_drv = cd;
    h_cs = hcs; h_rd = hrd; h_wr = hwr; h_addr = ha; h_din = hd;
    #1;
    if (!rst) compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic cpu_w(input logic [2:0] a, input logic [7:0] d);
    cyc(1, 0, 1, a, d, 0, 0, 0, 3, 0);
  endtask
  task automatic cpu_r(input logic [2:0] a);
    cyc(1, 1, 0, a, 0, 0, 0, 0, 3, 0);
  endtask
  task automatic host_w(input logic [1:0] a, input logic [7:0] d);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, a, d);
  endtask
  task automatic host_r(input logic [1:0] a);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, a, 0);
  endtask
  task automatic idle(input logic [1:0] ha);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, ha, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge clk);
    cyc(0,0,0,0,0,0,0,0,3,0);
    cyc(0,0,0,0,0,0,0,0,3,0);
    rst = 0;
    tag = "R1";
    for (int a = 0; a < 4; a++) idle(a[1:0]);
    cpu_r(1);
    tag = "R3";
    cpu_r(0);
    sw_n = 7'h2a; cpu_r(0);
    tag = "R5";
    cpu_w(1, 8'h81); cpu_r(1);
    cpu_w(2, 8'h3c); host_r(2);
    tag = "R2";
    cyc(0, 0, 1, 1, 8'hff, 0, 0, 0, 3, 0);
    cyc(0, 0, 1, 7, 8'h99, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 3, 8'h00, 0, 0, 0, 3, 0);
    cyc(0, 1, 0, 2, 8'h00, 0, 0, 0, 3, 0);
    cpu_r(1); idle(3);
    tag = "R6";
    cpu_w(3, 0); idle(3); cpu_r(0);
    cpu_w(4, 0); idle(3);
    tag = "R4";
    host_w(0, 8'ha7); idle(3); cpu_r(2); idle(3);
    tag = "R7";
    cpu_w(6, 8'h5e); host_r(0); idle(3);
    cpu_w(1, 8'h00); cpu_w(6, 8'h11); idle(3); host_r(0);
    cpu_w(1, 8'h01); cpu_w(6, 8'h22); idle(0); host_r(0); idle(3);
    tag = "R8";
    cpu_w(7, 8'hc3); idle(1); host_r(1); idle(1);
    tag = "R9";
    host_w(2, 8'h00); idle(3); cpu_w(5, 0); idle(3);
    tag = "R10";
    for (int a = 3; a < 8; a++) cpu_r(a[2:0]);
    cyc(0, 1, 0, 1, 0, 0, 0, 0, 3, 0);
    tag = "R11";
    cyc(1, 0, 1, 6, 8'h77, 1, 1, 0, 0, 0); idle(3);
    cyc(1, 0, 1, 7, 8'h44, 1, 1, 0, 1, 0); idle(1);
    cyc(1, 0, 1, 3, 8'h00, 1, 0, 1, 0, 8'h66); idle(3);
    host_w(0, 8'h12);
    cyc(1, 1, 0, 2, 8'h00, 1, 0, 1, 0, 8'h34); idle(3);
    tag = "R12";
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 8'hee); idle(3);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0); idle(3);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 0); idle(1);
    tag = "R1";
    rst = 1; idle(3); rst = 0;
    for (int a = 0; a < 4; a++) idle(a[1:0]);
    cpu_r(1);
    finish_run();
  end
endmodule